// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host write port of a NOR flash controller and turns a stream of bus write cycles into flash operations. Each accepted write presents an address and a data word; the decoder watches the low address bits and the low data byte for the fixed two-write unlock prefix, then for the command byte that follows, and after the final cycle of a recognised sequence it raises a one-cycle operation request carrying the kind of operation, the address and the full data word of that final write. The array sequencer downstream performs the actual program, erase, suspend or resume.

Alongside the sequence tracker the block keeps one lockdown bit per sector. Each request that programs a word or erases one sector is tagged when its target sector is locked. Two sticky mode flags are also produced. One marks product-identification mode, so the read path can return identification data. The other marks single-pulse programming, in which the unlock prefix is no longer needed and every write becomes a program request.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is active, and after it is released, op_valid, op_kind, op_locked, pid_mode and sp_mode are 0. All lockdown bits are clear and the decoder is idle.
- R2: Every multi-write sequence opens with data 0xAA at address 0x555 and then data 0x55 at address 0x2AA. Only wr_addr[10:0] and wr_data[7:0] take part in the comparison, so 0xAAA and any upper bits also match.
- R3: After the prefix, 0xA0 at 0x555 followed by any one write produces op_kind 1 (program). The request appears with op_valid high on the cycle after that write, and op_addr and op_data hold its address and full data.
- R4: After the prefix, 0x80 at 0x555 and a second prefix lead to a sixth write. 0x10 at 0x555 requests op_kind 2 (chip erase). 0x30 at any address requests op_kind 3 (sector erase) of the sector holding that address.
- R5: A sixth write of 0x60 requests op_kind 4 (lockdown) and sets the lockdown bit of the addressed sector. Words with wr_addr[19:15]==0 belong to sector wr_addr[14:12]; all other words belong to sector 7+wr_addr[19:15], 39 sectors in all.
- R6: op_locked is 1 exactly when a program or sector-erase request targets a locked sector. A chip-erase request never sets it.
- R7: 0x90 as the third write at 0x555 sets pid_mode. pid_mode is cleared by 0xF0 as the third write at 0x555, or by a lone write of 0xF0 at any address while idle.
- R8: A lone write of 0xB0 requests op_kind 5 (suspend) only while erase_busy is 1 and no erase is already suspended. A lone write of 0x30 while suspended requests op_kind 6 (resume), with wr_addr[19:18] in op_addr naming the plane. At any other time these writes produce nothing.
- R9: While an erase is suspended, a completed chip-erase or sector-erase sequence produces no request.
- R10: A sixth write of 0xA0 at 0x555 sets sp_mode. From then on every accepted write, whatever its code (erase and suspend codes included), produces a program request. Only reset clears sp_mode.
- R11: A write made while prog_busy is 1 produces no request and leaves the sequence state and all modes unchanged.
- R12: A write that does not match the next expected cycle of a sequence returns the decoder to idle without any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | One-cycle strobe marking a bus write |
| wr_addr | input | 20 | Word address of the write |
| wr_data | input | 16 | Data of the write; the low byte carries command codes |
| prog_busy | input | 1 | An embedded program is running; writes are ignored |
| erase_busy | input | 1 | An erase is running and may be suspended |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 3 | 1 program, 2 chip erase, 3 sector erase, 4 lockdown, 5 suspend, 6 resume |
| op_addr | output | 20 | Address of the final write of the sequence |
| op_data | output | 16 | Data of the final write of the sequence |
| op_locked | output | 1 | The program or sector-erase target is locked down |
| pid_mode | output | 1 | Product-identification mode active |
| sp_mode | output | 1 | Single-pulse program mode active |

## Verification
The bench builds the block with its default parameters: a 20-bit word address, an 11-bit command compare, eight small sectors of 4K words and thirty-two 32K-word regions, giving 39 lockdown bits. With these values the directed cases can reach both sector sizes, the boundary between small sector 7 and large sector 8, and the top sector 38. The random phase sets the address bits above bit 10 and the data bits above bit 7 freely on every prefix write, so the don't-care compare is exercised. Busy and suspend conditions land in the middle of sequences at random points.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_CHIP   = 3'd2,
    OP_SECT   = 3'd3,
    OP_LOCK   = 3'd4,
    OP_SUSP   = 3'd5,
    OP_RESUME = 3'd6
  } op_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PGM,
    ST_EXT3,
    ST_EXT4,
    ST_EXT5
  } seq_st_e;

  localparam logic [7:0] CD_KEY1    = 8'hAA;
  localparam logic [7:0] CD_KEY2    = 8'h55;
  localparam logic [7:0] CD_PROG    = 8'hA0;
  localparam logic [7:0] CD_EXT     = 8'h80;
  localparam logic [7:0] CD_PID_IN  = 8'h90;
  localparam logic [7:0] CD_PID_OUT = 8'hF0;
  localparam logic [7:0] CD_CHIP    = 8'h10;
  localparam logic [7:0] CD_SECT    = 8'h30;
  localparam logic [7:0] CD_LOCK    = 8'h60;
  localparam logic [7:0] CD_SUSP    = 8'hB0;

endpackage

// File: rtl/fcd_lock_table.sv
module fcd_lock_table #(
  parameter int ADDR_W      = 20,
  parameter int SMALL_CNT   = 8,
  parameter int SMALL_SHIFT = 12,
  parameter int BIG_SHIFT   = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          set_en,
  input  logic [ADDR_W-SMALL_SHIFT-1:0] sect_addr,
  output logic                          hit
);

  localparam int BIG_W    = ADDR_W - BIG_SHIFT;
  localparam int SUB_W    = BIG_SHIFT - SMALL_SHIFT;
  localparam int NUM_SECT = SMALL_CNT + (1 << BIG_W) - 1;
  localparam int SECT_W   = $clog2(NUM_SECT);

  logic [BIG_W-1:0]    big_part;
  logic [SUB_W-1:0]    sub_part;
  logic [SECT_W-1:0]   idx;
  logic [NUM_SECT-1:0] sel;
  logic [NUM_SECT-1:0] lock_q;

  assign big_part = sect_addr[ADDR_W-SMALL_SHIFT-1:SUB_W];
  assign sub_part = sect_addr[SUB_W-1:0];

  // Bottom region is split into small sectors, the rest into large ones.
  always_comb begin
    if (big_part == '0) idx = SECT_W'(sub_part);
    else                idx = SECT_W'(SMALL_CNT - 1) + SECT_W'(big_part);
  end

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_sel
    assign sel[i] = (idx == SECT_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (set_en) begin
      lock_q <= lock_q | sel;
    end
  end

  assign hit = |(lock_q & sel);

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int              ADDR_W = 20,
  parameter int              DATA_W = 16,
  parameter int              CMP_W  = 11,
  parameter logic [CMP_W-1:0] KEY_A = 11'h555,
  parameter logic [CMP_W-1:0] KEY_B = 11'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_busy,
  input  logic              erase_busy,
  input  logic              tgt_locked,
  output logic              lock_set,
  output logic              op_valid,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              op_locked,
  output logic              pid_mode,
  output logic              sp_mode
);

  seq_st_e  st_q, st_d;
  logic     pid_q, pid_d;
  logic     sp_q, sp_d;
  logic     susp_q, susp_d;
  op_kind_e kind_d, kind_q;
  logic     fire, valid_q, locked_q, locked_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic [CMP_W-1:0] cyc_a;
  logic [7:0]       cyc_c;
  logic             at_a, at_b, take;

  assign cyc_a = wr_addr[CMP_W-1:0];
  assign cyc_c = wr_data[7:0];
  assign at_a  = (cyc_a == KEY_A);
  assign at_b  = (cyc_a == KEY_B);
  assign take  = wr_en && !prog_busy;

  always_comb begin
    st_d     = st_q;
    pid_d    = pid_q;
    sp_d     = sp_q;
    susp_d   = susp_q;
    kind_d   = OP_NONE;
    lock_set = 1'b0;
    if (take) begin
      if (sp_q) begin
        kind_d = OP_PROG;
      end else begin
        st_d = ST_IDLE;
        unique case (st_q)
          ST_IDLE: begin
            if (at_a && cyc_c == CD_KEY1) begin
              st_d = ST_UNL1;
            end else if (cyc_c == CD_PID_OUT) begin
              pid_d = 1'b0;
            end else if (cyc_c == CD_SUSP) begin
              if (erase_busy && !susp_q) begin
                kind_d = OP_SUSP;
                susp_d = 1'b1;
              end
            end else if (cyc_c == CD_SECT) begin
              if (susp_q) begin
                kind_d = OP_RESUME;
                susp_d = 1'b0;
              end
            end
          end
          ST_UNL1: if (at_b && cyc_c == CD_KEY2) st_d = ST_UNL2;
          ST_UNL2: begin
            if (at_a) begin
              if      (cyc_c == CD_PROG)    st_d  = ST_PGM;
              else if (cyc_c == CD_EXT)     st_d  = ST_EXT3;
              else if (cyc_c == CD_PID_IN)  pid_d = 1'b1;
              else if (cyc_c == CD_PID_OUT) pid_d = 1'b0;
            end
          end
          ST_PGM:  kind_d = OP_PROG;
          ST_EXT3: if (at_a && cyc_c == CD_KEY1) st_d = ST_EXT4;
          ST_EXT4: if (at_b && cyc_c == CD_KEY2) st_d = ST_EXT5;
          ST_EXT5: begin
            if (at_a && cyc_c == CD_CHIP) begin
              if (!susp_q) kind_d = OP_CHIP;
            end else if (cyc_c == CD_SECT) begin
              if (!susp_q) kind_d = OP_SECT;
            end else if (cyc_c == CD_LOCK) begin
              kind_d   = OP_LOCK;
              lock_set = 1'b1;
            end else if (at_a && cyc_c == CD_PROG) begin
              sp_d = 1'b1;
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  assign fire     = (kind_d != OP_NONE);
  assign locked_d = tgt_locked && (kind_d == OP_PROG || kind_d == OP_SECT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pid_q    <= 1'b0;
      sp_q     <= 1'b0;
      susp_q   <= 1'b0;
      valid_q  <= 1'b0;
      kind_q   <= OP_NONE;
      locked_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      st_q     <= st_d;
      pid_q    <= pid_d;
      sp_q     <= sp_d;
      susp_q   <= susp_d;
      valid_q  <= fire;
      kind_q   <= kind_d;
      locked_q <= locked_d;
      if (fire) begin
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
    end
  end

  assign op_valid  = valid_q;
  assign op_kind   = kind_q;
  assign op_addr   = addr_q;
  assign op_data   = data_q;
  assign op_locked = locked_q;
  assign pid_mode  = pid_q;
  assign sp_mode   = sp_q;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int CMP_W       = 11,
  parameter int SMALL_CNT   = 8,
  parameter int SMALL_SHIFT = 12,
  parameter int BIG_SHIFT   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_busy,
  input  logic              erase_busy,
  output logic              op_valid,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              op_locked,
  output logic              pid_mode,
  output logic              sp_mode
);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       lock_set;
  logic       tgt_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  fcd_lock_table #(
    .ADDR_W      (ADDR_W),
    .SMALL_CNT   (SMALL_CNT),
    .SMALL_SHIFT (SMALL_SHIFT),
    .BIG_SHIFT   (BIG_SHIFT)
  ) u_lock (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .set_en    (lock_set),
    .sect_addr (wr_addr[ADDR_W-1:SMALL_SHIFT]),
    .hit       (tgt_locked)
  );

  fcd_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CMP_W  (CMP_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .prog_busy  (prog_busy),
    .erase_busy (erase_busy),
    .tgt_locked (tgt_locked),
    .lock_set   (lock_set),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_addr    (op_addr),
    .op_data    (op_data),
    .op_locked  (op_locked),
    .pid_mode   (pid_mode),
    .sp_mode    (sp_mode)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       prog_busy,
  input logic       op_valid,
  input logic [2:0] op_kind,
  input logic       op_locked,
  input logic       pid_mode,
  input logic       sp_mode
);

  a_r11_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prog_busy) |=> !op_valid);

  a_r12_quiet_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !op_valid);

  a_r10_sp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sp_mode |=> sp_mode);

  a_r10_sp_every_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_mode && wr_en && !prog_busy) |=> (op_valid && op_kind == 3'd1));

  a_r6_locked_kind: assert property (@(posedge clk) disable iff (!rst_n)
    op_locked |-> (op_valid && (op_kind == 3'd1 || op_kind == 3'd3)));

  a_r7_pid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pid_mode));

  a_r4_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (op_kind != 3'd0 && op_kind <= 3'd6));

endmodule

bind flash_cmd_decoder fcd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .prog_busy (prog_busy),
  .op_valid  (op_valid),
  .op_kind   (op_kind),
  .op_locked (op_locked),
  .pid_mode  (pid_mode),
  .sp_mode   (sp_mode)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, prog_busy, erase_busy;
  logic [19:0] wr_addr;
  logic [15:0] wr_data;
  logic        op_valid, op_locked, pid_mode, sp_mode;
  logic [2:0]  op_kind;
  logic [19:0] op_addr;
  logic [15:0] op_data;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  int       m_st;
  bit       m_pid, m_sp, m_susp;
  bit [38:0] m_lock;

  always #5 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_busy(prog_busy), .erase_busy(erase_busy), .op_valid(op_valid),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data), .op_locked(op_locked),
    .pid_mode(pid_mode), .sp_mode(sp_mode)
  );

  function automatic int sect_of(input logic [19:0] a);
    if (a[19:15] == 5'd0) return int'(a[14:12]);
    return 7 + int'(a[19:15]);
  endfunction

  task automatic model_reset();
    m_st = 0; m_pid = 0; m_sp = 0; m_susp = 0; m_lock = '0;
  endtask

  task automatic model(input logic [19:0] a, input logic [15:0] d, input bit b,
                       input bit eb, output bit ev, output int ek, output bit el);
    logic [10:0] lo;
    logic [7:0]  c;
    bit          lk;
    int          s;
    ev = 0; ek = 0; el = 0;
    if (b) return;
    lo = a[10:0]; c = d[7:0]; s = sect_of(a); lk = m_lock[s];
    if (m_sp) begin ev = 1; ek = 1; el = lk; return; end
    case (m_st)
      0: begin
        if (lo == 11'h555 && c == 8'hAA) m_st = 1;
        else if (c == 8'hF0) m_pid = 0;
        else if (c == 8'hB0) begin
          if (eb && !m_susp) begin ev = 1; ek = 5; m_susp = 1; end
        end else if (c == 8'h30) begin
          if (m_susp) begin ev = 1; ek = 6; m_susp = 0; end
        end
      end
      1: m_st = (lo == 11'h2AA && c == 8'h55) ? 2 : 0;
      2: begin
        m_st = 0;
        if (lo == 11'h555) begin
          if (c == 8'hA0) m_st = 3;
          else if (c == 8'h80) m_st = 4;
          else if (c == 8'h90) m_pid = 1;
          else if (c == 8'hF0) m_pid = 0;
        end
      end
      3: begin m_st = 0; ev = 1; ek = 1; el = lk; end
      4: m_st = (lo == 11'h555 && c == 8'hAA) ? 5 : 0;
      5: m_st = (lo == 11'h2AA && c == 8'h55) ? 6 : 0;
      default: begin
        m_st = 0;
        if (lo == 11'h555 && c == 8'h10) begin
          if (!m_susp) begin ev = 1; ek = 2; end
        end else if (c == 8'h30) begin
          if (!m_susp) begin ev = 1; ek = 3; el = lk; end
        end else if (c == 8'h60) begin
          ev = 1; ek = 4; m_lock[s] = 1'b1;
        end else if (lo == 11'h555 && c == 8'hA0) begin
          m_sp = 1;
        end
      end
    endcase
  endtask

  task automatic do_write(input logic [19:0] a, input logic [15:0] d, input bit b,
                          input bit eb, input string tag);
    bit ev, el;
    int ek;
    bit ok;
    model(a, d, b, eb, ev, ek, el);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; prog_busy = b; erase_busy = eb;
    @(negedge clk);
    wr_en = 1'b0; prog_busy = 1'b0;
    ok = (op_valid == ev) && (pid_mode == m_pid) && (sp_mode == m_sp);
    if (ev) ok = ok && (int'(op_kind) == ek) && (op_addr == a) && (op_data == d) && (op_locked == el);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: wr a=%h d=%h | actual v=%0b k=%0d a=%h d=%h lk=%0b pid=%0b sp=%0b | expected v=%0b k=%0d lk=%0b pid=%0b sp=%0b",
               tag, a, d, op_valid, op_kind, op_addr, op_data, op_locked, pid_mode, sp_mode,
               ev, ek, el, m_pid, m_sp);
    end
  endtask

  function automatic logic [19:0] hi_rand(input logic [10:0] lo);
    logic [31:0] r;
    r = $urandom;
    return {r[8:0], lo};
  endfunction

  function automatic logic [15:0] dat(input logic [7:0] c);
    logic [31:0] r;
    r = $urandom;
    return {r[7:0], c};
  endfunction

  task automatic prefix(input bit eb, input string tag);
    do_write(hi_rand(11'h555), dat(8'hAA), 0, eb, tag);
    do_write(hi_rand(($urandom % 2) ? 11'h2AA : 11'h2AA), dat(8'h55), 0, eb, tag);
  endtask

  task automatic cmd3(input logic [7:0] c, input bit eb, input string tag);
    prefix(eb, tag);
    do_write(hi_rand(11'h555), dat(c), 0, eb, tag);
  endtask

  task automatic cmd6(input logic [19:0] a, input logic [7:0] c, input bit eb, input string tag);
    cmd3(8'h80, eb, tag);
    prefix(eb, tag);
    do_write(a, dat(c), 0, eb, tag);
  endtask

  task automatic reset_check(input string tag);
    n_chk++;
    if (op_valid !== 1'b0 || op_kind !== 3'd0 || op_locked !== 1'b0 ||
        pid_mode !== 1'b0 || sp_mode !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: actual v=%0b k=%0d lk=%0b pid=%0b sp=%0b expected all 0",
               tag, op_valid, op_kind, op_locked, pid_mode, sp_mode);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    reset_check("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=run still going expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    wr_en = 0; prog_busy = 0; erase_busy = 0; wr_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    reset_check("R1 at start");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reset_check("R1 after release");

    // R7 identification mode enter / leave
    cmd3(8'h90, 0, "R7 pid enter");
    do_write(20'h3F00C, 16'h12F0, 0, 0, "R7 pid single exit");
    cmd3(8'h90, 0, "R7 pid enter again");
    cmd3(8'hF0, 0, "R7 pid three-write exit");

    // R2 prefix with 0xAAA alias and upper bits, R3 program
    do_write(20'hFF555, 16'hFFAA, 0, 0, "R2 first key upper bits");
    do_write(20'h00AAA, 16'h3355, 0, 0, "R2 alias 0xAAA");
    do_write(20'h80555, 16'h00A0, 0, 0, "R2 program code");
    do_write(20'h12345, 16'hBEEF, 0, 0, "R3 program request");

    // R5 lockdown, sector map, R6 locked flag
    cmd6(20'h05123, 8'h60, 0, "R5 lock small sector 5");
    cmd3(8'hA0, 0, "R6 prog setup");
    do_write(20'h05FFF, 16'h0001, 0, 0, "R6 program locked small");
    cmd3(8'hA0, 0, "R6 prog setup");
    do_write(20'h06000, 16'h0002, 0, 0, "R6 program unlocked neighbour");
    cmd6(20'h48000, 8'h60, 0, "R5 lock large sector 16");
    cmd6(20'h4FFFF, 8'h30, 0, "R6 sector erase locked");
    cmd6(20'h50000, 8'h30, 0, "R4 sector erase unlocked");
    cmd6(20'h07FFF, 8'h30, 0, "R4 sector erase small top");
    cmd6(20'hFFFFF, 8'h60, 0, "R5 lock top sector 38");
    cmd3(8'hA0, 0, "R6 prog setup");
    do_write(20'hF8000, 16'h0003, 0, 0, "R6 program top sector");
    cmd6(20'h00555, 8'h10, 0, "R4 chip erase no lock flag");

    // R8 suspend / resume, R9 erase refused while suspended
    do_write(20'h00000, 16'h00B0, 0, 0, "R8 suspend without erase");
    do_write(20'h00000, 16'h00B0, 0, 1, "R8 suspend");
    do_write(20'h00000, 16'h00B0, 0, 1, "R8 second suspend refused");
    cmd6(20'h60000, 8'h30, 1, "R9 sector erase while suspended");
    cmd6(20'h00555, 8'h10, 1, "R9 chip erase while suspended");
    cmd3(8'hA0, 1, "R3 program while suspended");
    do_write(20'h22222, 16'h5A5A, 0, 1, "R3 program while suspended");
    do_write(20'hC0123, 16'h0030, 0, 1, "R8 resume plane 3");
    do_write(20'hC0123, 16'h0030, 0, 1, "R8 resume without suspend");

    // R12 mismatches
    do_write(20'h00555, 16'h00AA, 0, 0, "R12 key1");
    do_write(20'h00556, 16'h0055, 0, 0, "R12 bad second address");
    do_write(20'h00555, 16'h00A0, 0, 0, "R12 no program after break");
    do_write(20'h01234, 16'h4321, 0, 0, "R12 still idle");
    cmd3(8'h80, 0, "R12 ext start");
    do_write(20'h00555, 16'h00AB, 0, 0, "R12 bad fourth data");
    do_write(20'h00AAA, 16'h0055, 0, 0, "R12 stray");
    do_write(20'h00555, 16'h0010, 0, 0, "R12 no chip erase");

    // R11 busy writes
    do_write(20'h00555, 16'h00AA, 0, 0, "R11 key1");
    do_write(20'h00123, 16'h0077, 1, 0, "R11 busy mid-prefix ignored");
    do_write(20'h002AA, 16'h0055, 0, 0, "R11 key2");
    do_write(20'h00555, 16'h00A0, 0, 0, "R11 program code");
    do_write(20'h33333, 16'h1111, 1, 0, "R11 busy data ignored");
    do_write(20'h33334, 16'h2222, 0, 0, "R11 program after busy");

    // random mix (R2 R12 and the rest through the reference)
    for (int i = 0; i < 3000; i++) begin
      int pick;
      bit eb;
      pick = int'($urandom % 10);
      eb = ($urandom % 2) == 1;
      if (pick < 4) begin
        logic [10:0] lo;
        logic [7:0]  c;
        int sel;
        sel = int'($urandom % 4);
        lo = (sel == 0) ? 11'h555 : (sel == 1) ? 11'h2AA : 11'($urandom);
        sel = int'($urandom % 11);
        case (sel)
          0: c = 8'hAA; 1: c = 8'h55; 2: c = 8'hA0; 3: c = 8'h80;
          4: c = 8'h90; 5: c = 8'hF0; 6: c = 8'hB0; 7: c = 8'h30;
          8: c = 8'h10; 9: c = 8'h60; default: c = 8'($urandom);
        endcase
        do_write(hi_rand(lo), dat(c), ($urandom % 8) == 0, eb, "R12 random write");
      end else begin
        logic [19:0] ta;
        ta = 20'($urandom);
        case (pick)
          4: begin cmd3(8'hA0, eb, "R3 random program"); do_write(ta, 16'($urandom), 0, eb, "R3 random program"); end
          5: cmd6(ta, 8'h30, eb, "R4 random sector erase");
          6: cmd6(ta, 8'h60, eb, "R5 random lock");
          7: cmd6(hi_rand(11'h555), 8'h10, eb, "R4 random chip erase");
          8: cmd3(($urandom % 2) ? 8'h90 : 8'hF0, eb, "R7 random pid");
          default: do_write(ta, dat(($urandom % 2) ? 8'hB0 : 8'h30), 0, eb, "R8 random suspend/resume");
        endcase
      end
    end

    // R1 reset clears locks and modes
    cmd6(20'h09000, 8'h60, 0, "R5 lock sector 8");
    do_reset();
    reset_check("R1 after mid-run reset");
    cmd3(8'hA0, 0, "R1 prog setup");
    do_write(20'h09000, 16'h4444, 0, 0, "R1 lock cleared by reset");

    // R10 single-pulse mode
    cmd6(20'h7F555, 8'hA0, 0, "R10 enter single pulse");
    do_write(20'h12000, 16'h00B0, 0, 1, "R10 suspend code programs");
    do_write(20'h00555, 16'h00AA, 0, 0, "R10 key code programs");
    do_write(20'h40000, 16'h0030, 0, 0, "R10 erase code programs");
    do_write(20'h40001, 16'h0010, 1, 0, "R11 busy in single pulse");
    do_write(20'h00000, 16'h00F0, 0, 0, "R10 exit code programs");
    do_reset();
    reset_check("R10 reset clears single pulse");
    do_write(20'h12000, 16'h00B0, 0, 0, "R10 no program after reset");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule